// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block sets the division ratio in the feedback path of a fractional-N phase-locked loop. It runs on the divided-down oscillator clock. It produces one single-clock feedback pulse per division cycle for the phase detector, and it outputs the ratio N of the cycle in progress. Over time, the average ratio equals INT + FRAC/MOD.

A third-order noise-shaping modulator varies N around INT. It is built from three cascaded accumulators that wrap at the programmable modulus MOD, which need not be a power of two. The modulator takes one step per feedback pulse. When FRAC is zero and the integer flag is set, the modulator is held cleared and every cycle divides by exactly INT.

Configuration values are captured on an update strobe. They are clamped into their legal ranges, and an error flag reports whether any clamping was needed. The captured values take effect only at a division-cycle boundary, and the modulator restarts from its cleared state at that boundary.

Top module: `fracn_divider`

## Requirements
- R1: While `rst` is high, and in the cycle in which it is released, `fb_pulse` is 1, `n_now` is 23 and `cfg_err` is 0. The configuration in force after reset is INT 23, FRAC 0, MOD 2, `presc_sel` 0 and `int_mode` 1.
- R2: `fb_pulse` is never high in two consecutive cycles. The spacing, in clocks, from one pulse to the next equals the `n_now` value shown during the cycle that ends with the second pulse. `n_now` changes only on the clock edge that follows a pulse.
- R3: Each cycle's N is INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''). Here c1, c2 and c3 are the carries of three cascaded accumulators. Each accumulator adds its input, subtracts MOD when the sum reaches MOD, and advances once per pulse. Stage 1 adds FRAC, stage 2 adds stage 1's new value, and stage 3 adds stage 2's new value. A prime marks the value of the previous step. N therefore lies in INT−3 to INT+4.
- R4: Count the T = k·MOD division cycles that follow the boundary at which a configuration takes effect. Their total clock count is k·(INT·MOD + FRAC) + e, with e in −1 to +2.
- R5: When FRAC is 0, every cycle divides by exactly INT, whether `int_mode` is 1 (modulator held cleared) or 0 (modulator restarted from its cleared state with zero input).
- R6: Values on the configuration inputs are captured in the cycle in which `upd` is 1. If `upd` is pulsed again before they take effect, the later values replace them. They take effect at the first `fb_pulse` seen in a cycle after the capture cycle. That pulse's cycle still shows the previous N. The modulator starts again from its cleared state at that boundary.
- R7: If INT is below its minimum, it is replaced by that minimum. The minimum is 23 when `presc_sel` is 0 and 75 when `presc_sel` is 1.
- R8: A MOD below 2 is replaced by 2. Then a FRAC that is not below the resulting MOD is replaced by MOD−1.
- R9: In the cycle after `upd`, `cfg_err` is 1 if any field was clamped and 0 otherwise. It holds that value until the next `upd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider clock (oscillator after the prescaler) |
| rst | input | 1 | Synchronous active-high reset |
| upd | input | 1 | Capture strobe for the configuration inputs |
| int_val | input | 16 | Integer part of the ratio |
| frac_val | input | 12 | Fraction numerator |
| mod_val | input | 12 | Fraction modulus |
| presc_sel | input | 1 | Prescaler select: 0 = 4/5, 1 = 8/9 (sets the INT minimum) |
| int_mode | input | 1 | Integer flag: with FRAC 0, holds the modulator cleared |
| fb_pulse | output | 1 | One-clock pulse ending each division cycle |
| n_now | output | 17 | Ratio N of the division cycle in progress |
| cfg_err | output | 1 | Last captured configuration needed clamping |

## Verification
The assertions take for granted that `upd` and the configuration inputs are driven synchronously to `clk`. They also take for granted that the values seen when `upd` is 1 are the ones intended. Nothing else is assumed about the inputs, because clamping keeps every legal or illegal value inside the ratio range that the spacing and range properties rely on. The stimulus changes the configuration inputs only half a cycle away from the active edge. It holds `upd` high for exactly one cycle per write. Back-to-back writes are placed inside a single long division cycle, so the replacement rule is exercised without a boundary falling between them.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int INT_W      = 16;
    localparam int MOD_W      = 12;
    localparam int N_W        = INT_W + 1;
    localparam int OFF_W      = 4;
    localparam int STAGES     = 3;
    localparam int INT_MIN_LO = 23;
    localparam int INT_MIN_HI = 75;
    localparam int MOD_MIN    = 2;

    typedef struct packed {
        logic [INT_W-1:0] int_v;
        logic [MOD_W-1:0] frac;
        logic [MOD_W-1:0] modv;
        logic             presc;
        logic             imode;
    } cfg_t;

    localparam cfg_t RESET_CFG = '{
        int_v: INT_W'(INT_MIN_LO),
        frac:  '0,
        modv:  MOD_W'(MOD_MIN),
        presc: 1'b0,
        imode: 1'b1
    };

    function automatic cfg_t clamp_cfg(cfg_t r);
        cfg_t o;
        logic [INT_W-1:0] lo;
        o  = r;
        lo = r.presc ? INT_W'(INT_MIN_HI) : INT_W'(INT_MIN_LO);
        if (r.int_v < lo) o.int_v = lo;
        if (r.modv < MOD_W'(MOD_MIN)) o.modv = MOD_W'(MOD_MIN);
        if (r.frac >= o.modv) o.frac = o.modv - 1'b1;
        return o;
    endfunction

    function automatic logic cfg_bad(cfg_t r);
        return clamp_cfg(r) != r;
    endfunction

endpackage

// File: rtl/fracn_cfg.sv
module fracn_cfg
    import fracn_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  cfg_t raw,
    input  logic boundary,
    output cfg_t eff,
    output logic apply,
    output logic err
);
    cfg_t act_q, pend_q;
    logic pend_v;

    assign apply = boundary && pend_v;
    assign eff   = apply ? pend_q : act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= RESET_CFG;
            pend_q <= RESET_CFG;
            pend_v <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (apply) act_q <= pend_q;
            if (upd) begin
                pend_q <= clamp_cfg(raw);
                err    <= cfg_bad(raw);
                pend_v <= 1'b1;
            end else if (apply) begin
                pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fracn_mash.sv
module fracn_mash
    import fracn_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    input  logic                    restart,
    input  logic                    hold,
    input  logic [MOD_W-1:0]        frac,
    input  logic [MOD_W-1:0]        modv,
    output logic signed [OFF_W-1:0] offset
);
    logic clr;
    assign clr = restart || hold;

    for (genvar g = 0; g < STAGES; g++) begin : stg
        logic [MOD_W-1:0] acc_q, din, base, dout;
        logic [MOD_W:0]   sum;
        logic             cy;
        if (g == 0) begin : g_first
            assign din = frac;
        end else begin : g_next
            assign din = stg[g-1].dout;
        end
        assign base = clr ? '0 : acc_q;
        assign sum  = {1'b0, base} + {1'b0, din};
        assign cy   = sum >= {1'b0, modv};
        assign dout = cy ? MOD_W'(sum - {1'b0, modv}) : sum[MOD_W-1:0];
        always_ff @(posedge clk) begin
            if (rst)       acc_q <= '0;
            else if (step) acc_q <= hold ? '0 : dout;
        end
    end

    logic c2d_q, c3d_q, c3dd_q;
    logic c2d, c3d, c3dd;
    assign c2d  = clr ? 1'b0 : c2d_q;
    assign c3d  = clr ? 1'b0 : c3d_q;
    assign c3dd = clr ? 1'b0 : c3dd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c2d_q  <= 1'b0;
            c3d_q  <= 1'b0;
            c3dd_q <= 1'b0;
        end else if (step) begin
            c2d_q  <= hold ? 1'b0 : stg[1].cy;
            c3d_q  <= hold ? 1'b0 : stg[2].cy;
            c3dd_q <= hold ? 1'b0 : c3d;
        end
    end

    logic [OFF_W-1:0] raw_off;
    assign raw_off = OFF_W'(stg[0].cy) + OFF_W'(stg[1].cy) - OFF_W'(c2d)
                   + OFF_W'(stg[2].cy) - OFF_W'({c3d, 1'b0}) + OFF_W'(c3dd);
    assign offset  = hold ? '0 : $signed(raw_off);
endmodule

// File: rtl/fracn_counter.sv
module fracn_counter
    import fracn_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [INT_W-1:0]        int_v,
    input  logic signed [OFF_W-1:0] offset,
    output logic                    fb_pulse,
    output logic [N_W-1:0]          n_now
);
    logic [N_W-1:0]        cnt;
    logic signed [N_W:0]   n_sum;
    logic [N_W-1:0]        n_next;

    assign n_sum    = $signed({2'b00, int_v}) + $signed({{(N_W+1-OFF_W){offset[OFF_W-1]}}, offset});
    assign n_next   = n_sum[N_W-1:0];
    assign fb_pulse = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            n_now <= N_W'(INT_MIN_LO);
        end else if (fb_pulse) begin
            cnt   <= n_next - 1'b1;
            n_now <= n_next;
        end else begin
            cnt   <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [15:0]      int_val,
    input  logic [11:0]      frac_val,
    input  logic [11:0]      mod_val,
    input  logic             presc_sel,
    input  logic             int_mode,
    output logic             fb_pulse,
    output logic [16:0]      n_now,
    output logic             cfg_err
);
    cfg_t raw, eff;
    logic apply, hold;
    logic signed [OFF_W-1:0] offset;

    assign raw = '{int_v: int_val, frac: frac_val, modv: mod_val,
                   presc: presc_sel, imode: int_mode};
    assign hold = eff.imode && (eff.frac == '0);

    fracn_cfg u_cfg (
        .clk(clk), .rst(rst), .upd(upd), .raw(raw), .boundary(fb_pulse),
        .eff(eff), .apply(apply), .err(cfg_err)
    );

    fracn_mash u_mash (
        .clk(clk), .rst(rst), .step(fb_pulse), .restart(apply), .hold(hold),
        .frac(eff.frac), .modv(eff.modv), .offset(offset)
    );

    fracn_counter u_cnt (
        .clk(clk), .rst(rst), .int_v(eff.int_v), .offset(offset),
        .fb_pulse(fb_pulse), .n_now(n_now)
    );
endmodule

// File: rtl/fracn_checker.sv
module fracn_checker (
    input logic        clk,
    input logic        rst,
    input logic        upd,
    input logic [15:0] int_val,
    input logic        presc_sel,
    input logic        fb_pulse,
    input logic [16:0] n_now,
    input logic        cfg_err
);
    logic [16:0] gap;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (fb_pulse) begin
            gap  <= 17'd1;
            seen <= 1'b1;
        end else begin
            gap  <= gap + 1'b1;
        end
    end

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    p_gap_match_r2: assert property (@(posedge clk) disable iff (rst)
        (fb_pulse && seen) |-> (gap == n_now));

    p_n_steady_r2: assert property (@(posedge clk) disable iff (rst)
        !fb_pulse |=> $stable(n_now));

    p_n_bounds_r3: assert property (@(posedge clk) disable iff (rst)
        (n_now >= 17'd20) && (n_now <= 17'd65539));

    p_err_low_int_r9: assert property (@(posedge clk) disable iff (rst)
        (upd && ((!presc_sel && int_val < 16'd23) || (presc_sel && int_val < 16'd75)))
        |=> cfg_err);

    p_err_kept_r9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(cfg_err));
endmodule

bind fracn_divider fracn_checker u_chk (
    .clk(clk), .rst(rst), .upd(upd), .int_val(int_val), .presc_sel(presc_sel),
    .fb_pulse(fb_pulse), .n_now(n_now), .cfg_err(cfg_err)
);

// File: tb/fracn_divider_test.sv
module fracn_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd = 1'b0;
    logic [15:0] int_val = '0;
    logic [11:0] frac_val = '0;
    logic [11:0] mod_val = '0;
    logic        presc_sel = 1'b0;
    logic        int_mode = 1'b0;
    logic        fb_pulse;
    logic [16:0] n_now;
    logic        cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    fracn_divider uut (
        .clk(clk), .rst(rst), .upd(upd), .int_val(int_val), .frac_val(frac_val),
        .mod_val(mod_val), .presc_sel(presc_sel), .int_mode(int_mode),
        .fb_pulse(fb_pulse), .n_now(n_now), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int a_int, a_frac, a_mod, a_im;
    int p_int, p_frac, p_mod, p_im;
    int pv, m_cnt, m_n, m_err;
    int acc1, acc2, acc3, c2d, c3d, c3dd;

    always @(posedge clk) begin
        if (rst) begin
            a_int = 23; a_frac = 0; a_mod = 2; a_im = 1;
            p_int = 23; p_frac = 0; p_mod = 2; p_im = 1;
            pv = 0; m_cnt = 0; m_n = 23; m_err = 0;
            acc1 = 0; acc2 = 0; acc3 = 0; c2d = 0; c3d = 0; c3dd = 0;
        end else begin
            if (m_cnt == 0) begin
                int ei, ef, em, eim, off, c1, c2, c3;
                bit ap;
                ap  = (pv != 0);
                ei  = ap ? p_int  : a_int;
                ef  = ap ? p_frac : a_frac;
                em  = ap ? p_mod  : a_mod;
                eim = ap ? p_im   : a_im;
                if (ap || (eim != 0 && ef == 0)) begin
                    acc1 = 0; acc2 = 0; acc3 = 0; c2d = 0; c3d = 0; c3dd = 0;
                end
                if (eim != 0 && ef == 0) begin
                    off = 0;
                end else begin
                    acc1 += ef;   c1 = (acc1 >= em) ? 1 : 0; if (c1 != 0) acc1 -= em;
                    acc2 += acc1; c2 = (acc2 >= em) ? 1 : 0; if (c2 != 0) acc2 -= em;
                    acc3 += acc2; c3 = (acc3 >= em) ? 1 : 0; if (c3 != 0) acc3 -= em;
                    off  = c1 + c2 - c2d + c3 - 2 * c3d + c3dd;
                    c3dd = c3d; c3d = c3; c2d = c2;
                end
                m_n   = ei + off;
                m_cnt = m_n - 1;
                if (ap) begin
                    a_int = p_int; a_frac = p_frac; a_mod = p_mod; a_im = p_im;
                    pv = 0;
                end
            end else begin
                m_cnt--;
            end
            if (upd) begin
                int lo, ci, cm, cf;
                lo = presc_sel ? 75 : 23;
                ci = (int_val < lo) ? lo : int_val;
                cm = (mod_val < 2) ? 2 : mod_val;
                cf = (frac_val >= cm) ? cm - 1 : frac_val;
                m_err = (ci != int_val || cm != mod_val || cf != frac_val) ? 1 : 0;
                p_int = ci; p_mod = cm; p_frac = cf; p_im = int_mode;
                pv = 1;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_range(input string what, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", what, act, lo, hi);
        end
    endtask

    task automatic finish_up();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 fb_pulse vs model", int'(fb_pulse), (m_cnt == 0) ? 1 : 0);
            chk("R3 n_now vs model", int'(n_now), m_n);
            chk("R9 cfg_err vs model", int'(cfg_err), m_err);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    task automatic write_cfg(input int i, input int f, input int m, input int p, input int im);
        @(negedge clk);
        int_val = 16'(i); frac_val = 12'(f); mod_val = 12'(m);
        presc_sel = p[0]; int_mode = im[0]; upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
    endtask

    task automatic run_window(input string tag, input int t_pulses, input int lo, input int hi,
                              input int n_lo, input int n_hi, input int old_n);
        int cycles, pulses, mn, mx;
        while (fb_pulse !== 1'b1) @(negedge clk);
        if (old_n >= 0) chk({tag, " R6 previous N kept in boundary cycle"}, int'(n_now), old_n);
        cycles = 0; pulses = 0; mn = 1 << 30; mx = 0;
        while (pulses < t_pulses) begin
            @(negedge clk);
            cycles++;
            if (int'(n_now) < mn) mn = int'(n_now);
            if (int'(n_now) > mx) mx = int'(n_now);
            if (fb_pulse) pulses++;
        end
        chk_range({tag, " R4 clock total"}, cycles, lo, hi);
        chk_range({tag, " R3 min N"}, mn, n_lo, n_hi);
        chk_range({tag, " R3 max N"}, mx, n_lo, n_hi);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pulse in reset", int'(fb_pulse), 1);
        chk("R1 n_now in reset", int'(n_now), 23);
        rst = 1'b0;
        chk("R1 pulse at release", int'(fb_pulse), 1);
        chk("R1 n_now at release", int'(n_now), 23);
        chk("R1 cfg_err at release", int'(cfg_err), 0);
        @(negedge clk);
        chk("R1 default ratio", int'(n_now), 23);

        // R5 integer mode, exact
        write_cfg(100, 0, 7, 0, 1);
        chk("R9 legal cfg no error", int'(cfg_err), 0);
        run_window("R5 int-mode", 21, 2100, 2100, 100, 100, 23);

        // R3/R4 fractional, small modulus
        write_cfg(100, 3, 7, 0, 1);
        run_window("R4 frac 3/7", 28, 2812 - 1, 2812 + 2, 97, 104, 100);

        // R4 large non-power-of-two modulus, 8/9 prescaler
        write_cfg(80, 377, 1000, 1, 0);
        run_window("R4 frac 377/1000", 1000, 80377 - 1, 80377 + 2, 77, 84, -1);

        // R5 FRAC zero with integer flag clear
        write_cfg(300, 0, 5, 0, 0);
        run_window("R5 frac0 flag0", 10, 3000, 3000, 300, 300, -1);

        // R7/R8 clamps: INT 10->23, FRAC 9->4 with MOD 5
        write_cfg(10, 9, 5, 0, 1);
        chk("R9 clamp raises error", int'(cfg_err), 1);
        run_window("R7 R8 clamp lo", 10, 238 - 1, 238 + 2, 20, 27, -1);
        chk("R9 error held", int'(cfg_err), 1);

        // R7/R8: INT 50->75 with 8/9, MOD 1->2, FRAC 0
        write_cfg(50, 0, 1, 1, 1);
        chk("R9 clamp raises error p1", int'(cfg_err), 1);
        run_window("R7 R8 clamp hi", 4, 300, 300, 75, 75, -1);

        // R6 back-to-back writes: the second replaces the first
        write_cfg(5000, 0, 3, 1, 1);
        write_cfg(1000, 2, 3, 1, 1);
        chk("R9 legal cfg clears error", int'(cfg_err), 0);
        run_window("R6 replace", 9, 9006 - 1, 9006 + 2, 997, 1004, 75);

        finish_up();
    end
endmodule